// File: doc/BRIEF.md
# Absolute-to-Quadrature Encoder Emulator

This block turns an absolute angle word, which changes over time, into the signals of an incremental encoder. It produces two quadrature outputs A and B, a once-per-revolution zero marker and a direction flag. Downstream counters and motor-control logic can then treat an absolute angle source as if it were an ordinary incremental encoder.

The block keeps its own tracked position at one of four resolutions, chosen by a two-bit select. Each clock it moves the tracked position one step toward the quantised input angle. Every step advances or retreats the A/B Gray sequence by one state, so large jumps in the input come out as a burst of correctly ordered edges, one per clock. While the input is flagged invalid, all outputs freeze. The first valid cycle after reset, and any change of resolution, reload the tracked position from the input without stepping toward it.

Top module: `enc_quad_emu`

## Requirements
- R1: The output pair {A,B} is a function of the tracked count c = (tracked position >> drop) mod 4: c=0 gives A=1,B=1; c=1 gives A=0,B=1; c=2 gives A=0,B=0; c=3 gives A=1,B=0. So when the angle increases, A leads B, and between two clocks at most one of A and B toggles.
- R2: DIR goes to 1 after a step that increases the tracked position, goes to 0 after a step that decreases it, and otherwise holds. Its reset value is 1.
- R3: The marker output is high exactly while the tracked position equals zero, where A and B are both high. This gives one rising edge of the marker per full revolution.
- R4: The select word {res_sel_i[1],res_sel_i[0]} sets the resolution: 00 is 10 bits (drop 6), 10 is 12 bits (drop 4), 01 is 14 bits (drop 2), 11 is 16 bits (drop 0). The tracked position uses only the top bits of pos_i, and changes to the dropped low bits cause no edge.
- R5: Per clock, the tracked position moves at most one step of 2^drop toward the target, along the shorter way round. When the target is exactly half a revolution away, the step is downward.
- R6: While sig_valid_i is low, A, B, the marker and DIR hold their values and no step is taken.
- R7: On the first valid cycle after reset, and on any valid cycle whose select differs from the one last loaded, the tracked position is loaded directly with the quantised input. This load takes no stepping and leaves DIR unchanged.
- R8: In reset, A=1, B=1, the marker is 1 and DIR is 1 (tracked position zero).
- R9: A full increasing revolution at resolution r produces 2^(r-2) rising edges on A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pos_i | input | POS_W (16) | Absolute angle word, full scale one revolution |
| res_sel_i | input | 2 | Resolution select, encoding in R4 |
| sig_valid_i | input | 1 | Input angle valid; low freezes the block |
| enc_a_o | output | 1 | Quadrature output A |
| enc_b_o | output | 1 | Quadrature output B |
| marker_o | output | 1 | Zero-position marker |
| dir_o | output | 1 | Direction, 1 for increasing angle |

## Verification
All outputs are registered. An input sampled at one rising edge shows its effect from that edge on. The bench therefore drives inputs just after a falling edge and reads outputs at the next falling edge, one cycle later. A jump of N steps is judged after N such cycles, and a reload or resolution change is judged one cycle after it is applied. A behavioural model stepped on the same rising edges is compared against A/B, the marker and DIR at every falling edge. Directed checks count edges over known windows to cover the revolution count, catch-up length, tie direction, frozen outputs and sub-step changes that must be ignored.

// File: rtl/enc_emu_pkg.sv
package enc_emu_pkg;

    // Resolution codes as {sel[1], sel[0]}
    typedef enum logic [1:0] {
        RES_COARSE = 2'b00,   // POS_W-6 bits
        RES_MID    = 2'b10,   // POS_W-4 bits
        RES_FINE   = 2'b01,   // POS_W-2 bits
        RES_FULL   = 2'b11    // POS_W bits
    } res_code_e;

    // Number of low angle bits discarded for a resolution code
    function automatic int unsigned drop_bits(res_code_e code);
        case (code)
            RES_COARSE: return 6;
            RES_MID:    return 4;
            RES_FINE:   return 2;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/enc_res_decode.sv
module enc_res_decode
    import enc_emu_pkg::*;
#(
    parameter int unsigned POS_W = 16,
    parameter int unsigned SH_W  = $clog2(POS_W)
) (
    input  logic [1:0]       res_sel_i,
    output logic [SH_W-1:0]  shift_o,
    output logic [POS_W-1:0] mask_o,
    output logic [POS_W-1:0] step_o
);
    logic [POS_W-1:0] ones;

    always_comb begin
        ones    = '1;
        shift_o = SH_W'(drop_bits(res_code_e'(res_sel_i)));
        mask_o  = ones << shift_o;
        step_o  = {{(POS_W-1){1'b0}}, 1'b1} << shift_o;
    end
endmodule

// File: rtl/enc_step_calc.sv
module enc_step_calc #(
    parameter int unsigned POS_W = 16
) (
    input  logic [POS_W-1:0] trk_i,
    input  logic [POS_W-1:0] target_i,
    input  logic [POS_W-1:0] step_i,
    output logic             need_o,
    output logic             up_o,
    output logic [POS_W-1:0] trk_o
);
    logic [POS_W-1:0] diff;

    always_comb begin
        diff   = target_i - trk_i;            // modular distance
        need_o = |diff;
        up_o   = ~diff[POS_W-1];              // half turn (MSB only) goes down
        trk_o  = up_o ? (trk_i + step_i) : (trk_i - step_i);
    end
endmodule

// File: rtl/enc_quad_phase.sv
module enc_quad_phase #(
    parameter int unsigned POS_W = 16,
    parameter int unsigned SH_W  = $clog2(POS_W)
) (
    input  logic [POS_W-1:0] trk_i,
    input  logic [SH_W-1:0]  shift_i,
    output logic             a_o,
    output logic             b_o,
    output logic             nm_o
);
    logic c0, c1;

    always_comb begin
        c0   = trk_i[shift_i];
        c1   = trk_i[shift_i + SH_W'(1)];
        // count 0 sits on A=B=1 so the marker lands in that quarter
        a_o  = ~c1 ^ c0;
        b_o  = ~c1;
        nm_o = (trk_i == '0);
    end
endmodule

// File: rtl/enc_quad_emu.sv
module enc_quad_emu #(
    parameter int unsigned POS_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [POS_W-1:0] pos_i,
    input  logic [1:0]       res_sel_i,
    input  logic             sig_valid_i,
    output logic             enc_a_o,
    output logic             enc_b_o,
    output logic             marker_o,
    output logic             dir_o
);
    localparam int unsigned SH_W = $clog2(POS_W);

    typedef struct packed {
        logic [POS_W-1:0] trk;
        logic [1:0]       res;
        logic             init;
        logic             a;
        logic             b;
        logic             nm;
        logic             dir;
    } emu_st_t;

    emu_st_t st_d, st_q;

    logic [SH_W-1:0]  shift;
    logic [POS_W-1:0] mask, step, target, trk_step, trk_nxt;
    logic             need, up, reload, ph_a, ph_b, ph_nm;

    enc_res_decode #(.POS_W(POS_W), .SH_W(SH_W)) u_res (
        .res_sel_i (res_sel_i),
        .shift_o   (shift),
        .mask_o    (mask),
        .step_o    (step)
    );

    assign target = pos_i & mask;
    assign reload = sig_valid_i && (!st_q.init || (res_sel_i != st_q.res));

    enc_step_calc #(.POS_W(POS_W)) u_step (
        .trk_i    (st_q.trk),
        .target_i (target),
        .step_i   (step),
        .need_o   (need),
        .up_o     (up),
        .trk_o    (trk_step)
    );

    always_comb begin
        if (reload)    trk_nxt = target;
        else if (need) trk_nxt = trk_step;
        else           trk_nxt = st_q.trk;
    end

    enc_quad_phase #(.POS_W(POS_W), .SH_W(SH_W)) u_phase (
        .trk_i   (trk_nxt),
        .shift_i (shift),
        .a_o     (ph_a),
        .b_o     (ph_b),
        .nm_o    (ph_nm)
    );

    always_comb begin
        st_d = st_q;
        if (sig_valid_i) begin
            st_d.trk = trk_nxt;
            st_d.a   = ph_a;
            st_d.b   = ph_b;
            st_d.nm  = ph_nm;
            if (reload) begin
                st_d.init = 1'b1;
                st_d.res  = res_sel_i;
            end else if (need) begin
                st_d.dir  = up;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.trk  <= '0;
            st_q.res  <= '0;
            st_q.init <= 1'b0;
            st_q.a    <= 1'b1;
            st_q.b    <= 1'b1;
            st_q.nm   <= 1'b1;
            st_q.dir  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign enc_a_o  = st_q.a;
    assign enc_b_o  = st_q.b;
    assign marker_o = st_q.nm;
    assign dir_o    = st_q.dir;
endmodule

// File: rtl/enc_quad_emu_chk.sv
module enc_quad_emu_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sig_valid_i,
    input logic reload_i,
    input logic enc_a_o,
    input logic enc_b_o,
    input logic marker_o,
    input logic dir_o
);
    // R1: at most one quadrature line toggles per clock outside a reload
    a_r1_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sig_valid_i && !reload_i) |=>
        ($countones({enc_a_o, enc_b_o} ^ $past({enc_a_o, enc_b_o})) <= 1));

    // R3: marker only in the quarter where A and B are both high
    a_r3_marker_at_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        marker_o |-> (enc_a_o && enc_b_o));

    // R6: invalid input freezes every output
    a_r6_hold_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sig_valid_i |=> $stable({enc_a_o, enc_b_o, marker_o, dir_o}));

    // R2: direction changes only together with a quadrature step
    a_r2_dir_with_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sig_valid_i && !reload_i) |=> ($stable(dir_o) || !$stable({enc_a_o, enc_b_o})));
endmodule

bind enc_quad_emu enc_quad_emu_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sig_valid_i (sig_valid_i),
    .reload_i    (reload),
    .enc_a_o     (enc_a_o),
    .enc_b_o     (enc_b_o),
    .marker_o    (marker_o),
    .dir_o       (dir_o)
);

// File: tb/enc_quad_emu_tb.sv
`timescale 1ns/1ps
module enc_quad_emu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pos = 16'h1234;
    logic [1:0]  sel = 2'b00;
    logic        valid = 1'b0;
    logic        a, b, nm, dir;

    int n_cmp = 0, n_bad = 0;
    bit done = 0, cmp_en = 0;

    always #5 clk = ~clk;

    enc_quad_emu u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pos_i(pos), .res_sel_i(sel),
        .sig_valid_i(valid), .enc_a_o(a), .enc_b_o(b), .marker_o(nm), .dir_o(dir)
    );

    // ---------------- behavioural reference ----------------
    int m_trk = 0, m_res = 0, m_drop, m_stp, m_tgt, m_dif;
    bit m_init = 0, m_a = 1, m_b = 1, m_nm = 1, m_dir = 1;

    function automatic int drop_of(input logic [1:0] s);
        case (s)
            2'b00: return 6;
            2'b10: return 4;
            2'b01: return 2;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_trk = 0; m_res = 0; m_init = 0;
            m_a = 1; m_b = 1; m_nm = 1; m_dir = 1;
        end else if (valid) begin
            m_drop = drop_of(sel);
            m_stp  = 1 << m_drop;
            m_tgt  = int'(pos) & (65536 - m_stp);
            if (!m_init || int'(sel) != m_res) begin
                m_trk = m_tgt; m_init = 1; m_res = int'(sel);
            end else if (m_trk != m_tgt) begin
                m_dif = (m_tgt - m_trk + 65536) % 65536;
                if (m_dif < 32768) begin m_trk = (m_trk + m_stp) % 65536; m_dir = 1; end
                else begin m_trk = (m_trk - m_stp + 65536) % 65536; m_dir = 0; end
            end
            case ((m_trk >> m_drop) % 4)
                0: begin m_a = 1; m_b = 1; end
                1: begin m_a = 0; m_b = 1; end
                2: begin m_a = 0; m_b = 0; end
                default: begin m_a = 1; m_b = 0; end
            endcase
            m_nm = (m_trk == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check({a, b} == {m_a, m_b}, "R1 quad levels", int'({a, b}), int'({m_a, m_b}));
            check(nm == m_nm, "R3 marker", int'(nm), int'(m_nm));
            check(dir == m_dir, "R2 direction", int'(dir), int'(m_dir));
        end
    end

    // edge counters
    int ab_edges = 0, a_rises = 0, nm_rises = 0;
    logic pa = 1, pb = 1, pn = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            ab_edges += int'(a != pa) + int'(b != pb);
            a_rises  += int'(a && !pa);
            nm_rises += int'(nm && !pn);
        end
        pa = a; pb = b; pn = nm;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    int e0, r0, n0;
    logic [3:0] snap;

    initial begin
        cyc(3);
        // R8 reset state
        check({a, b, nm, dir} == 4'b1111, "R8 reset state", int'({a, b, nm, dir}), 15);
        rst_n = 1'b1;
        cmp_en = 1;
        cyc(4);
        // R6 invalid after reset: nothing moves
        check({a, b, nm, dir} == 4'b1111, "R6 hold before valid", int'({a, b, nm, dir}), 15);

        // R7 load 0x1234 at 10 bits: count 72 -> A=1,B=1, marker 0
        valid = 1'b1;
        cyc(1);
        check({a, b, nm, dir} == 4'b1101, "R7 load levels", int'({a, b, nm, dir}), 13);
        e0 = ab_edges;
        cyc(4);
        check(ab_edges == e0, "R7 no stepping after load", ab_edges - e0, 0);

        // R5 catch-up: five coarse steps down, one per clock
        pos = 16'h1234 - 16'd320;
        e0 = ab_edges;
        cyc(5);
        check(ab_edges - e0 == 5, "R5 five steps in five clocks", ab_edges - e0, 5);
        check(dir == 1'b0, "R2 dir low after down steps", int'(dir), 0);
        cyc(2);
        check(ab_edges - e0 == 5, "R5 caught up", ab_edges - e0, 5);

        // move to zero, R3 marker with A=B=1
        pos = 16'h0000;
        cyc(80);
        check({nm, a, b} == 3'b111, "R3 marker at zero", int'({nm, a, b}), 7);

        // R9 full increasing revolution at 10 bits
        r0 = a_rises; n0 = nm_rises;
        for (int i = 1; i <= 1024; i++) begin
            pos = 16'((i * 64) % 65536);
            cyc(1);
        end
        cyc(2);
        check(a_rises - r0 == 256, "R9 A cycles per revolution", a_rises - r0, 256);
        check(nm_rises - n0 == 1, "R3 one marker per revolution", nm_rises - n0, 1);
        check(dir == 1'b1, "R2 dir high after up steps", int'(dir), 1);

        // R5 half-turn tie goes down
        pos = 16'h8000;
        cyc(2);
        check(dir == 1'b0, "R5 half turn steps down", int'(dir), 0);
        cyc(520);

        // R6 invalid freezes outputs
        valid = 1'b0;
        pos = 16'h0000;
        snap = {a, b, nm, dir};
        e0 = ab_edges;
        cyc(10);
        check({a, b, nm, dir} == snap, "R6 outputs frozen", int'({a, b, nm, dir}), int'(snap));
        check(ab_edges == e0, "R6 no edges while invalid", ab_edges - e0, 0);
        valid = 1'b1;
        cyc(600);

        // R4/R7 switch to 12 bits: 0x0ABC -> count 0xAB, c=3 -> A=1,B=0
        sel = 2'b10;
        pos = 16'h0ABC;
        cyc(1);
        check({a, b} == 2'b10, "R4 reload at 12 bits", int'({a, b}), 2);
        pos = 16'h0ABF;
        e0 = ab_edges;
        cyc(4);
        check(ab_edges == e0, "R4 dropped bits ignored", ab_edges - e0, 0);

        // random walks at 16 and 14 bits, model-checked every clock
        sel = 2'b11;
        for (int i = 0; i < 300; i++) begin
            pos = pos + 16'($urandom_range(6)) - 16'd3;
            cyc(1);
        end
        sel = 2'b01;
        for (int i = 0; i < 300; i++) begin
            pos = pos + 16'($urandom_range(160)) - 16'd80;
            cyc(1);
        end
        cyc(100);
        finish_run();
    end
endmodule